// File: doc/BRIEF.md
# Serial Transmit Queue with Qualified Empty Interrupt

This block is the sending half of a byte-oriented asynchronous serial port. The CPU pushes bytes into a 16-deep queue. A shift stage pulls each byte out as soon as it is free and sends it on `txd` as an 8N1 frame: one low start bit, eight data bits with the least significant bit first, and one high stop bit. The frame advances on a one-cycle `baud_tick` enable from an external rate generator, and `txd` rests high between frames.

The queue raises `tx_irq` when it is empty and `irq_en` is set, so that software can refill it. A single byte written into an empty queue leaves it again almost at once. In that case the interrupt would normally fire again while the service routine is still running. To prevent this, the block holds the interrupt off for one character time (10 baud ticks). The hold-off is armed after reset and again each time the queue drains. It is disarmed once two bytes have been queued at the same moment. When the queue drains after that, the interrupt rises at once.

The CPU side is a valid/ready pair, with `wr_ready` equal to the inverse of `fifo_full`. A source should hold off while `wr_ready` is low. A `wr_valid` pulse offered while the queue is full is not stalled. It is discarded, and the sticky `wr_overflow` flag is set. That flag clears only on reset.

Top module: `serial_tx_queue`

## Requirements
- R1: After reset, `txd` is 1, `fifo_empty` is 1, `fifo_full` is 0, `wr_ready` is 1, `wr_overflow` is 0, and `tx_irq` equals `irq_en`.
- R2: A frame drives `txd` low for the start bit until the first `baud_tick` after the load. Each of the next eight ticks presents one data bit, bit 0 first. The 9th tick presents the stop bit (1). The 10th tick returns the line to idle (1) and frees the shift stage.
- R3: A byte accepted while the queue is empty and the shift stage is idle moves to the shift stage on the next clock edge. `txd` goes low on that same edge.
- R4: The queue holds at most 16 bytes. `fifo_full` is 1 and `wr_ready` is 0 while it holds 16. Both clear on the clock edge at which the next byte moves to the shift stage.
- R5: A write offered while `fifo_full` is 1 is discarded and never sent. It sets `wr_overflow`, which stays 1 until reset.
- R6: `tx_irq` is 1 only while the queue is empty and `irq_en` is 1, and it is always 0 while `irq_en` is 0.
- R7: If the queue drains while the hold-off is armed, `tx_irq` stays 0 until 10 baud ticks after the draining edge. This is the same tick that ends the frame.
- R8: Once the queue has held two or more bytes at once, the edge that drains it raises `tx_irq` (with `irq_en` at 1) with no delay.
- R9: Every time the queue drains, the hold-off is armed again, so a later single byte is once more followed by the delay.
- R10: Bytes leave on `txd` in the order they were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | CPU offers a byte |
| wr_ready | output | 1 | Queue can take a byte (not full) |
| wr_data | input | 8 | Byte to send |
| irq_en | input | 1 | Transmit interrupt enable |
| baud_tick | input | 1 | One-cycle bit-time enable |
| txd | output | 1 | Serial output, idles high |
| fifo_full | output | 1 | Queue holds 16 bytes |
| fifo_empty | output | 1 | Queue holds no byte |
| tx_irq | output | 1 | Qualified queue-empty interrupt |
| wr_overflow | output | 1 | Sticky: a write was discarded while full |

## Verification
The assertions assume that `baud_tick` is a single-cycle strobe that comes from a synchronous source. They also assume that `irq_en` changes only at clock granularity, because `tx_irq` follows it through logic without a register. The bench drives every input half a cycle away from the active edge and pulses `baud_tick` once every fourth cycle. It stops the tick stream whenever it needs to pile bytes up in the queue, for example to fill it, to overflow it, or to make two bytes coexist. That way the queue depth the checks depend on is set only by the write sequence.

// File: rtl/stq_pkg.sv
package stq_pkg;
  typedef enum logic {
    SH_IDLE = 1'b0,
    SH_SEND = 1'b1
  } sh_state_e;

  // start bit plus stop bit around the data bits
  localparam int FRAME_OVERHEAD = 2;
endpackage

// File: rtl/stq_fifo.sv
module stq_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] head_data,
  output logic [CNT_W-1:0]  count,
  output logic              full,
  output logic              empty
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;

  function automatic logic [PTR_W-1:0] next_ptr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= next_ptr(wr_ptr);
      if (pop)  rd_ptr <= next_ptr(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end

  assign head_data = mem[rd_ptr];
  assign full      = (count == CNT_W'(DEPTH));
  assign empty     = (count == '0);
endmodule

// File: rtl/stq_shifter.sv
module stq_shifter
  import stq_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int CHAR_TICKS = DATA_W + FRAME_OVERHEAD,
  localparam int BC_W = $clog2(CHAR_TICKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              baud_tick,
  output logic              busy,
  output logic              txd
);
  sh_state_e         state;
  logic [DATA_W:0]   sreg;
  logic [BC_W-1:0]   bit_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= SH_IDLE;
      sreg    <= '1;
      bit_cnt <= '0;
      txd     <= 1'b1;
    end else begin
      case (state)
        SH_IDLE: begin
          if (load) begin
            state   <= SH_SEND;
            sreg    <= {1'b1, load_data};
            bit_cnt <= '0;
            txd     <= 1'b0;
          end
        end
        SH_SEND: begin
          if (baud_tick) begin
            if (bit_cnt == BC_W'(CHAR_TICKS - 1)) begin
              state <= SH_IDLE;
              txd   <= 1'b1;
            end else begin
              txd     <= sreg[0];
              sreg    <= {1'b1, sreg[DATA_W:1]};
              bit_cnt <= bit_cnt + BC_W'(1);
            end
          end
        end
        default: state <= SH_IDLE;
      endcase
    end
  end

  assign busy = (state == SH_SEND);
endmodule

// File: rtl/stq_irq_qual.sv
module stq_irq_qual #(
  parameter int  CNT_W      = 5,
  parameter int  CHAR_TICKS = 10,
  parameter bit  DELAY_EN   = 1'b1,
  localparam int TC_W = $clog2(CHAR_TICKS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] count,
  input  logic             push,
  input  logic             pop,
  input  logic             irq_en,
  input  logic             baud_tick,
  output logic             holdoff,
  output logic             irq
);
  logic draining;
  assign draining = pop && !push && (count == CNT_W'(1));

  generate
    if (DELAY_EN) begin : g_delay
      logic            armed;
      logic            hold_q;
      logic [TC_W-1:0] tick_cnt;

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          armed    <= 1'b1;
          hold_q   <= 1'b0;
          tick_cnt <= '0;
        end else begin
          // two bytes resident at once disarm the delay
          if (count >= CNT_W'(2))  armed <= 1'b0;
          else if (draining)       armed <= 1'b1;

          if (draining) begin
            hold_q   <= armed;
            tick_cnt <= '0;
          end else if (hold_q && baud_tick) begin
            if (tick_cnt == TC_W'(CHAR_TICKS - 1)) begin
              hold_q   <= 1'b0;
              tick_cnt <= '0;
            end else begin
              tick_cnt <= tick_cnt + TC_W'(1);
            end
          end
        end
      end
      assign holdoff = hold_q;
    end else begin : g_nodelay
      assign holdoff = 1'b0;
    end
  endgenerate

  assign irq = irq_en && (count == '0) && !holdoff;
endmodule

// File: rtl/serial_tx_queue.sv
module serial_tx_queue
  import stq_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int DEPTH    = 16,
  parameter bit DELAY_EN = 1'b1,
  localparam int CNT_W      = $clog2(DEPTH + 1),
  localparam int CHAR_TICKS = DATA_W + FRAME_OVERHEAD
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              irq_en,
  input  logic              baud_tick,
  output logic              txd,
  output logic              fifo_full,
  output logic              fifo_empty,
  output logic              tx_irq,
  output logic              wr_overflow
);
  logic              push, load, busy, holdoff;
  logic [DATA_W-1:0] head_data;
  logic [CNT_W-1:0]  count;

  assign wr_ready = !fifo_full;
  assign push     = wr_valid && wr_ready;
  assign load     = !busy && !fifo_empty;

  stq_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .push_data (wr_data),
    .pop       (load),
    .head_data (head_data),
    .count     (count),
    .full      (fifo_full),
    .empty     (fifo_empty)
  );

  stq_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .load_data (head_data),
    .baud_tick (baud_tick),
    .busy      (busy),
    .txd       (txd)
  );

  stq_irq_qual #(.CNT_W(CNT_W), .CHAR_TICKS(CHAR_TICKS), .DELAY_EN(DELAY_EN)) u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .count     (count),
    .push      (push),
    .pop       (load),
    .irq_en    (irq_en),
    .baud_tick (baud_tick),
    .holdoff   (holdoff),
    .irq       (tx_irq)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                      wr_overflow <= 1'b0;
    else if (wr_valid && fifo_full)  wr_overflow <= 1'b1;
  end
endmodule

// File: rtl/stq_checker.sv
module stq_checker #(
  parameter int DEPTH = 16,
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_valid,
  input logic             wr_ready,
  input logic             fifo_full,
  input logic             fifo_empty,
  input logic             wr_overflow,
  input logic             tx_irq,
  input logic             irq_en,
  input logic             txd,
  input logic             baud_tick,
  input logic             load,
  input logic             holdoff,
  input logic [CNT_W-1:0] count
);
  // R4
  full_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full |-> !wr_ready);

  // R4
  depth_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));

  // R5
  overflow_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && fifo_full) |=> wr_overflow);

  // R5
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_overflow |=> wr_overflow);

  // R6
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq |-> (fifo_empty && irq_en));

  // R7
  holdoff_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    holdoff |-> !tx_irq);

  // R2
  txd_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!baud_tick && !load) |=> $stable(txd));

  // R3
  start_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !txd);
endmodule

bind serial_tx_queue stq_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_valid    (wr_valid),
  .wr_ready    (wr_ready),
  .fifo_full   (fifo_full),
  .fifo_empty  (fifo_empty),
  .wr_overflow (wr_overflow),
  .tx_irq      (tx_irq),
  .irq_en      (irq_en),
  .txd         (txd),
  .baud_tick   (baud_tick),
  .load        (load),
  .holdoff     (holdoff),
  .count       (count)
);

// File: tb/serial_tx_queue_tb.sv
module serial_tx_queue_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n, wr_valid, irq_en, baud_tick;
  logic [7:0] wr_data;
  logic       wr_ready, txd, fifo_full, fifo_empty, tx_irq, wr_overflow;
  bit         tick_run;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  // bit 8 = irq_en, bits 7:0 = byte sent alone into an empty queue
  localparam logic [8:0] VECS [6] = '{9'h1A5, 9'h05A, 9'h1FF, 9'h100, 9'h03C, 9'h181};

  serial_tx_queue u_dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .irq_en(irq_en), .baud_tick(baud_tick), .txd(txd),
    .fifo_full(fifo_full), .fifo_empty(fifo_empty), .tx_irq(tx_irq),
    .wr_overflow(wr_overflow)
  );

  initial begin
    int div = 0;
    baud_tick = 1'b0;
    forever begin
      @(negedge clk);
      div++;
      baud_tick = tick_run && (div % 4 == 0);
    end
  end

  task automatic report();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic send(logic [7:0] d);
    wr_valid = 1'b1;
    wr_data  = d;
    step();
    wr_valid = 1'b0;
  endtask

  // mode 0: no irq check, 1: hold-off expected, 2: irq follows ie, 3: irq low
  task automatic check_frame(logic [7:0] d, int mode, bit ie, string itag);
    int w = 0;
    while (txd !== 1'b0 && w < 400) begin
      step();
      w++;
    end
    chk("R2 start bit", int'(txd), 0);
    if (mode == 1) chk(itag, int'(tx_irq), 0);
    if (mode == 2) chk(itag, int'(tx_irq), int'(ie));
    if (mode == 3) chk(itag, int'(tx_irq), 0);
    for (int i = 0; i < 10; i++) begin
      do @(posedge clk); while (baud_tick !== 1'b1);
      step();
      chk("R2 R10 frame bit", int'(txd), (i < 8) ? int'(d[i]) : 1);
      if (mode == 1) chk(itag, int'(tx_irq), (i == 9) ? int'(ie) : 0);
      if (mode == 2) chk(itag, int'(tx_irq), int'(ie));
      if (mode == 3) chk(itag, int'(tx_irq), 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    report();
  end

  initial begin
    rst_n = 1'b0; wr_valid = 1'b0; wr_data = '0; irq_en = 1'b1; tick_run = 1'b0;
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // R1 reset state
    chk("R1 txd", int'(txd), 1);
    chk("R1 empty", int'(fifo_empty), 1);
    chk("R1 full", int'(fifo_full), 0);
    chk("R1 ready", int'(wr_ready), 1);
    chk("R1 overflow", int'(wr_overflow), 0);
    chk("R1 irq", int'(tx_irq), 1);

    // R3 start latency, ticks stopped
    send(8'hC3);
    chk("R3 no start yet", int'(txd), 1);
    chk("R3 queued", int'(fifo_empty), 0);
    step();
    chk("R3 start bit", int'(txd), 0);
    chk("R3 drained", int'(fifo_empty), 1);
    chk("R7 irq held", int'(tx_irq), 0);
    tick_run = 1'b1;
    check_frame(8'hC3, 1, 1'b1, "R7 holdoff");

    // vector table: single bytes, hold-off and enable gating
    for (int v = 0; v < 6; v++) begin
      irq_en = VECS[v][8];
      send(VECS[v][7:0]);
      check_frame(VECS[v][7:0], 1, VECS[v][8], "R6 R7 irq");
    end
    irq_en = 1'b0;
    step();
    chk("R6 irq off", int'(tx_irq), 0);
    irq_en = 1'b1;
    step();
    chk("R6 irq on", int'(tx_irq), 1);

    // R8: two bytes coexist, drain raises irq at once
    tick_run = 1'b0;
    step();
    send(8'h11);
    send(8'h22);
    send(8'h33);
    tick_run = 1'b1;
    check_frame(8'h11, 3, 1'b1, "R8 busy low");
    check_frame(8'h22, 3, 1'b1, "R8 busy low");
    check_frame(8'h33, 2, 1'b1, "R8 fast irq");

    // R9: re-armed, single byte delayed again
    send(8'h96);
    check_frame(8'h96, 1, 1'b1, "R9 rearm");

    // R4 / R5: fill, overflow, release
    tick_run = 1'b0;
    step();
    for (int i = 0; i < 17; i++) send(8'h40 + 8'(i));
    chk("R4 full", int'(fifo_full), 1);
    chk("R4 not ready", int'(wr_ready), 0);
    chk("R5 no overflow yet", int'(wr_overflow), 0);
    send(8'hEE);
    chk("R5 overflow set", int'(wr_overflow), 1);
    chk("R4 still full", int'(fifo_full), 1);
    tick_run = 1'b1;
    check_frame(8'h40, 0, 1'b1, "");
    chk("R4 full until move", int'(fifo_full), 1);
    step();
    chk("R4 full clears", int'(fifo_full), 0);
    chk("R4 ready again", int'(wr_ready), 1);
    for (int i = 1; i < 17; i++) check_frame(8'h40 + 8'(i), 0, 1'b1, "");
    repeat (60) step();
    chk("R5 dropped byte not sent", int'(txd), 1);
    chk("R5 queue empty", int'(fifo_empty), 1);
    chk("R5 overflow sticky", int'(wr_overflow), 1);
    chk("R8 irq after burst", int'(tx_irq), 1);
    report();
  end
endmodule